// File: doc/BRIEF.md
# Completion Packet Receive Checker

This block watches an incoming stream of 32-bit completion words. Each word carries a valid strobe and start and end flags. After an arm pulse it hunts for the first word flagged as a packet start. It then collects up to four dwords and, when the end flag arrives, issues a verdict: success, not found, or malformed. On a one-dword read whose data arrived, it also hands back that data word.

Two budgets keep the hunt and the collection bounded, so the block cannot wait forever. The first is a count of cycles from the arm pulse until a start word shows up. The second is a count of idle cycles between words once a packet has begun. A request engine arms the checker just after it issues a non-posted request. It then waits for the done pulse and reads the verdict. An optional tag compare rejects a completion that belongs to some other request.

Top module: `cpl_rx_checker`

## Requirements
- R1: While reset is held and in the first cycle after it, `done_o` is 0, `code_o` is 2'b00, `rdata_vld_o` is 0 and `rdata_o` is 0.
- R2: An `arm_i` pulse starts a hunt. During the hunt, valid words without `w_sop_i` are dropped, and every hunt cycle counts toward a budget of TIMEOUT cycles. A start word in the TIMEOUT-th cycle after the arm cycle is still accepted.
- R3: If no start word arrives within those TIMEOUT cycles, `done_o` rises in the cycle TIMEOUT+1 cycles after the arm cycle, with `code_o` = 2'b01 (not found).
- R4: The completion status is bits 15:13 of the second word of the packet. Any nonzero status gives `code_o` = 2'b01 with `rdata_vld_o` = 0.
- R5: The byte count is bits 11:0 of the second word. `rdata_vld_o` is 1 only when all four of these hold: the verdict is success, the byte count is 4, a fourth word was received, and that fourth word carried `w_end` (`w_eop_i`). In that case `rdata_o` equals the fourth word. Otherwise `rdata_o` is 0.
- R6: A three-word packet with zero status and a matching tag ends with `code_o` = 2'b00 and `rdata_vld_o` = 0.
- R7: The result is `code_o` = 2'b10 (malformed) in each of these cases, whatever the status: the fourth word lacks the end flag; the end flag comes on the first word; the end flag comes on the second word.
- R8: Inside a packet, a run of TIMEOUT idle cycles without a valid word gives `code_o` = 2'b10. A gap of TIMEOUT-1 idle cycles is tolerated.
- R9: A start word arriving while a packet is being collected discards the earlier words and restarts collection from that word.
- R10: With CHECK_TAG set, bits 15:8 of the third word must equal `exp_tag_i`. A mismatch gives `code_o` = 2'b10, and this takes precedence over a nonzero status.
- R11: `done_o` is a single-cycle pulse. `code_o`, `rdata_o` and `rdata_vld_o` change only in a cycle where `done_o` is 1, and they hold their values until the next done pulse.
- R12: Words arriving while the checker is not armed are ignored and produce no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Start hunting for a completion |
| exp_tag_i | input | 8 | Tag expected in the third word |
| w_valid_i | input | 1 | Word strobe |
| w_data_i | input | 32 | Word contents |
| w_sop_i | input | 1 | Word is the first of a packet |
| w_eop_i | input | 1 | Word is the last of a packet |
| done_o | output | 1 | One-cycle verdict strobe |
| code_o | output | 2 | 00 success, 01 not found, 10 malformed |
| rdata_o | output | 32 | Captured read data |
| rdata_vld_o | output | 1 | Read data is valid |

## Verification
The bench sweeps every status value against byte counts of 0, 3, 4 and 5, in both three- and four-word packets. A design that read the wrong header bits, or that returned data on a byte count other than four, would report data or a verdict the arithmetic model rejects. Both budgets are tested at their exact edges: TIMEOUT-1 versus TIMEOUT idle cycles, and the precise cycle of the not-found pulse. An off-by-one counter would accept a late start word, or reject a legal gap, one cycle early. Further cases cover a restart in mid-packet, a tag mismatch that hides a bad status, and words sent before arming. A design that missed any of these would report stale headers, pick the wrong verdict, or pulse done without being armed.

// File: rtl/cpl_chk_pkg.sv
package cpl_chk_pkg;

    localparam int DW_W  = 32;
    localparam int TAG_W = 8;
    localparam int BC_W  = 12;
    localparam int ST_W  = 3;
    localparam int IDX_W = 2;

    typedef enum logic [1:0] {
        RES_OK        = 2'b00,
        RES_NOT_FOUND = 2'b01,
        RES_MALFORMED = 2'b10
    } cpl_res_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HUNT    = 2'd1,
        ST_COLLECT = 2'd2
    } cpl_state_e;

    typedef struct packed {
        logic [ST_W-1:0] status;
        logic [BC_W-1:0] bcnt;
    } cpl_hdr1_t;

    function automatic cpl_hdr1_t hdr1_fields(input logic [DW_W-1:0] w);
        cpl_hdr1_t r;
        r.status = w[15:13];
        r.bcnt   = w[11:0];
        return r;
    endfunction

    function automatic logic [TAG_W-1:0] tag_field(input logic [DW_W-1:0] w);
        return w[15:8];
    endfunction

    // Verdict precedence: length, then tag, then status.
    function automatic cpl_res_e judge(input logic short_pkt, input logic tag_ok,
                                       input logic [ST_W-1:0] status);
        if (short_pkt)       return RES_MALFORMED;
        if (!tag_ok)         return RES_MALFORMED;
        if (status != '0)    return RES_NOT_FOUND;
        return RES_OK;
    endfunction

endpackage

// File: rtl/cpl_budget_ctr.sv
module cpl_budget_ctr #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic expired_o
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (step && !expired_o)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/cpl_hdr_latch.sv
module cpl_hdr_latch
    import cpl_chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ld_hdr1,
    input  logic             ld_hdr2,
    input  logic [DW_W-1:0]  word_i,
    output cpl_hdr1_t        hdr1_o,
    output logic [TAG_W-1:0] tag_o
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hdr1_o <= '0;
            tag_o  <= '0;
        end else begin
            if (ld_hdr1) hdr1_o <= hdr1_fields(word_i);
            if (ld_hdr2) tag_o  <= tag_field(word_i);
        end
    end
endmodule

// File: rtl/cpl_tag_cmp.sv
module cpl_tag_cmp
    import cpl_chk_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic [TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0] exp_i,
    output logic             ok_o
);
    generate
        if (ENABLE) begin : g_cmp
            assign ok_o = (tag_i == exp_i);
        end else begin : g_pass
            logic unused_tags;
            assign unused_tags = ^{tag_i, exp_i};
            assign ok_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/cpl_rx_checker.sv
module cpl_rx_checker
    import cpl_chk_pkg::*;
#(
    parameter int TIMEOUT   = 16,
    parameter bit CHECK_TAG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic [TAG_W-1:0] exp_tag_i,
    input  logic             w_valid_i,
    input  logic [DW_W-1:0]  w_data_i,
    input  logic             w_sop_i,
    input  logic             w_eop_i,
    output logic             done_o,
    output logic [1:0]       code_o,
    output logic [DW_W-1:0]  rdata_o,
    output logic             rdata_vld_o
);
    localparam logic [IDX_W-1:0] IDX_HDR1 = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_HDR2 = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(3);
    localparam logic [BC_W-1:0]  BC_ONE_DW = BC_W'(4);

    cpl_state_e       st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    cpl_res_e         code_q, res;
    logic             fin, vld_d;
    logic             hunting, collecting, sop_w, expired, tag_ok;
    logic             ctr_clr, lat_clr, ld1, ld2;
    cpl_hdr1_t        hdr1_q;
    logic [TAG_W-1:0] tag_q, tag_now;

    assign hunting    = (st_q == ST_HUNT);
    assign collecting = (st_q == ST_COLLECT);
    assign sop_w      = w_valid_i && w_sop_i;

    assign ctr_clr = arm_i || (st_q == ST_IDLE) || (hunting && sop_w)
                   || (collecting && w_valid_i);
    assign lat_clr = (hunting || collecting) && sop_w;
    assign ld1 = collecting && w_valid_i && !w_sop_i && (idx_q == IDX_HDR1);
    assign ld2 = collecting && w_valid_i && !w_sop_i && (idx_q == IDX_HDR2);
    assign tag_now = (idx_q == IDX_HDR2) ? tag_field(w_data_i) : tag_q;

    cpl_budget_ctr #(.LIMIT(TIMEOUT)) budget_i (
        .clk(clk), .rst(rst), .clr(ctr_clr),
        .step(hunting || collecting), .expired_o(expired)
    );

    cpl_hdr_latch hdr_i (
        .clk(clk), .rst(rst), .clr(lat_clr), .ld_hdr1(ld1), .ld_hdr2(ld2),
        .word_i(w_data_i), .hdr1_o(hdr1_q), .tag_o(tag_q)
    );

    cpl_tag_cmp #(.ENABLE(CHECK_TAG)) tag_i (
        .tag_i(tag_now), .exp_i(exp_tag_i), .ok_o(tag_ok)
    );

    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        fin   = 1'b0;
        res   = RES_OK;
        vld_d = 1'b0;
        if (arm_i) begin
            st_d  = ST_HUNT;
            idx_d = '0;
        end else begin
            unique case (st_q)
                ST_HUNT: begin
                    if (sop_w) begin
                        if (w_eop_i) begin
                            fin  = 1'b1;
                            res  = RES_MALFORMED;
                            st_d = ST_IDLE;
                        end else begin
                            st_d  = ST_COLLECT;
                            idx_d = IDX_HDR1;
                        end
                    end else if (expired) begin
                        fin  = 1'b1;
                        res  = RES_NOT_FOUND;
                        st_d = ST_IDLE;
                    end
                end
                ST_COLLECT: begin
                    if (w_valid_i) begin
                        if (w_sop_i && !w_eop_i) begin
                            idx_d = IDX_HDR1;
                        end else if (w_eop_i) begin
                            fin   = 1'b1;
                            st_d  = ST_IDLE;
                            res   = judge(w_sop_i || (idx_q == IDX_HDR1), tag_ok,
                                          hdr1_q.status);
                            vld_d = (res == RES_OK) && (idx_q == IDX_DATA)
                                 && (hdr1_q.bcnt == BC_ONE_DW);
                        end else if (idx_q == IDX_DATA) begin
                            fin  = 1'b1;
                            res  = RES_MALFORMED;
                            st_d = ST_IDLE;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end else if (expired) begin
                        fin  = 1'b1;
                        res  = RES_MALFORMED;
                        st_d = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            idx_q       <= '0;
            done_o      <= 1'b0;
            code_q      <= RES_OK;
            rdata_o     <= '0;
            rdata_vld_o <= 1'b0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            done_o <= fin;
            if (fin) begin
                code_q      <= res;
                rdata_vld_o <= vld_d;
                rdata_o     <= vld_d ? w_data_i : '0;
            end
        end
    end

    assign code_o = code_q;
endmodule

// File: rtl/cpl_rx_checker_sva.sv
module cpl_rx_checker_sva (
    input logic        clk,
    input logic        rst,
    input logic        done_o,
    input logic [1:0]  code_o,
    input logic [31:0] rdata_o,
    input logic        rdata_vld_o
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done_o && code_o == 2'b00 && !rdata_vld_o && rdata_o == '0));

    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_vld_needs_ok_r5: assert property (@(posedge clk) disable iff (rst)
        rdata_vld_o |-> (code_o == 2'b00));

    p_code_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_o) |-> done_o);

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!$stable(rdata_o) || !$stable(rdata_vld_o)) |-> done_o);

    p_code_legal_r7: assert property (@(posedge clk) disable iff (rst)
        code_o != 2'b11);
endmodule

bind cpl_rx_checker cpl_rx_checker_sva chk_i (
    .clk(clk), .rst(rst), .done_o(done_o), .code_o(code_o),
    .rdata_o(rdata_o), .rdata_vld_o(rdata_vld_o)
);

// File: tb/cpl_rx_checker_tb.sv
module cpl_rx_checker_tb_top;
    localparam int CLK_P = 10;
    localparam int TO    = 5;
    localparam logic [7:0] ETAG = 8'h3C;
    localparam logic [31:0] DW0 = 32'h4A000001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm_i = 1'b0;
    logic w_valid_i = 1'b0, w_sop_i = 1'b0, w_eop_i = 1'b0;
    logic [31:0] w_data_i = '0;
    logic done_o, rdata_vld_o;
    logic [1:0] code_o;
    logic [31:0] rdata_o;

    int nchk = 0, nfail = 0, ndone = 0;
    logic [1:0] lcode;
    logic lvld;
    logic [31:0] ldata;

    always #(CLK_P/2) clk = ~clk;

    cpl_rx_checker #(.TIMEOUT(TO), .CHECK_TAG(1'b1)) dut_i (
        .clk(clk), .rst(rst), .arm_i(arm_i), .exp_tag_i(ETAG),
        .w_valid_i(w_valid_i), .w_data_i(w_data_i), .w_sop_i(w_sop_i),
        .w_eop_i(w_eop_i), .done_o(done_o), .code_o(code_o),
        .rdata_o(rdata_o), .rdata_vld_o(rdata_vld_o)
    );

    always @(negedge clk) if (done_o) begin
        ndone = ndone + 1;
        lcode = code_o;
        lvld  = rdata_vld_o;
        ldata = rdata_o;
    end

    function automatic logic [31:0] h1(input logic [2:0] st, input logic [11:0] bc);
        return {16'h0100, st, 1'b0, bc};
    endfunction
    function automatic logic [31:0] h2(input logic [7:0] tg);
        return {16'h0000, tg, 8'h04};
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", what, act, exp);
        end
    endtask

    task automatic arm();
        @(negedge clk);
        arm_i = 1'b1; w_valid_i = 1'b0; w_sop_i = 1'b0; w_eop_i = 1'b0;
    endtask
    task automatic drive(input logic [31:0] d, input logic s, input logic e);
        @(negedge clk);
        arm_i = 1'b0; w_valid_i = 1'b1; w_data_i = d; w_sop_i = s; w_eop_i = e;
    endtask
    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            arm_i = 1'b0; w_valid_i = 1'b0; w_sop_i = 1'b0; w_eop_i = 1'b0;
        end
    endtask

    task automatic expect_res(input string req, input logic [1:0] c,
                              input logic v, input logic [31:0] d);
        for (int i = 0; i < 40 && ndone == 0; i++) @(posedge clk);
        idle(3);
        chk(ndone == 1, {req, " done count"}, 32'(ndone), 32'd1);
        chk(lcode == c, {req, " code"}, 32'(lcode), 32'(c));
        chk(lvld == v && ldata == d, {req, " data"}, ldata, d);
        ndone = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog: got hung expected finish");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!done_o && code_o == 2'b00 && !rdata_vld_o && rdata_o == '0,
            "R1 reset outputs", {29'd0, done_o, code_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done_o && code_o == 2'b00 && !rdata_vld_o && rdata_o == '0,
            "R1 first cycle after reset", {29'd0, done_o, code_o}, 32'd0);

        // Sweep: status x byte count x length (R4 R5 R6)
        for (int st = 0; st < 8; st++) begin
            for (int b = 0; b < 4; b++) begin
                for (int len = 3; len <= 4; len++) begin
                    logic [11:0] bc;
                    logic [31:0] dat;
                    logic ev;
                    bc  = (b == 0) ? 12'd0 : (b == 1) ? 12'd3 : (b == 2) ? 12'd4 : 12'd5;
                    dat = 32'hA5000000 ^ (st * 64 + b * 8 + len);
                    ev  = (st == 0) && (bc == 12'd4) && (len == 4);
                    arm();
                    drive(DW0, 1'b1, 1'b0);
                    drive(h1(3'(st), bc), 1'b0, 1'b0);
                    drive(h2(ETAG), 1'b0, len == 3);
                    if (len == 4) drive(dat, 1'b0, 1'b1);
                    expect_res(st != 0 ? "R4 sweep" : (ev ? "R5 sweep" : "R6 sweep"),
                               st != 0 ? 2'b01 : 2'b00, ev, ev ? dat : 32'd0);
                end
            end
        end

        // R2: words ahead of start dropped
        arm();
        drive(32'hDEAD0001, 1'b0, 1'b0);
        drive(32'hDEAD0002, 1'b0, 1'b1);
        drive(DW0, 1'b1, 1'b0);
        drive(h1(3'd0, 12'd4), 1'b0, 1'b0);
        drive(h2(ETAG), 1'b0, 1'b0);
        drive(32'h11223344, 1'b0, 1'b1);
        expect_res("R2 discard before start", 2'b00, 1'b1, 32'h11223344);

        // R2: start in last budget cycle accepted
        arm();
        idle(TO - 1);
        drive(DW0, 1'b1, 1'b0);
        drive(h1(3'd0, 12'd4), 1'b0, 1'b0);
        drive(h2(ETAG), 1'b0, 1'b0);
        drive(32'h55667788, 1'b0, 1'b1);
        expect_res("R2 late start accepted", 2'b00, 1'b1, 32'h55667788);

        // R3 and R12: start one cycle too late
        arm();
        idle(TO);
        drive(DW0, 1'b1, 1'b0);
        drive(h1(3'd0, 12'd4), 1'b0, 1'b0);
        drive(h2(ETAG), 1'b0, 1'b0);
        drive(32'h99999999, 1'b0, 1'b1);
        expect_res("R3 start too late", 2'b01, 1'b0, 32'd0);

        // R3 exact cycle, R11 pulse width
        begin
            int first;
            first = -1;
            arm();
            for (int j = 1; j <= TO + 3; j++) begin
                idle(1);
                if (done_o && first < 0) first = j;
            end
            chk(first == TO + 1, "R3 timeout cycle", 32'(first), 32'(TO + 1));
            ndone = 0;
        end
        arm();
        idle(TO + 1);
        chk(done_o == 1'b1, "R11 pulse present", {31'd0, done_o}, 32'd1);
        idle(1);
        chk(done_o == 1'b0, "R11 pulse one cycle", {31'd0, done_o}, 32'd0);
        idle(4);
        chk(code_o == 2'b01, "R11 code held", 32'(code_o), 32'd1);
        ndone = 0;

        // R7 malformed shapes
        arm();
        drive(DW0, 1'b1, 1'b0);
        drive(h1(3'd0, 12'd4), 1'b0, 1'b0);
        drive(h2(ETAG), 1'b0, 1'b0);
        drive(32'h12121212, 1'b0, 1'b0);
        idle(1);
        expect_res("R7 four words no end", 2'b10, 1'b0, 32'd0);
        arm();
        drive(DW0, 1'b1, 1'b1);
        expect_res("R7 end on first word", 2'b10, 1'b0, 32'd0);
        arm();
        drive(DW0, 1'b1, 1'b0);
        drive(h1(3'd6, 12'd4), 1'b0, 1'b1);
        expect_res("R7 end on second word", 2'b10, 1'b0, 32'd0);

        // R8 gap limits
        arm();
        drive(DW0, 1'b1, 1'b0);
        drive(h1(3'd0, 12'd0), 1'b0, 1'b0);
        idle(TO - 1);
        drive(h2(ETAG), 1'b0, 1'b1);
        expect_res("R8 gap tolerated", 2'b00, 1'b0, 32'd0);
        arm();
        drive(DW0, 1'b1, 1'b0);
        drive(h1(3'd0, 12'd0), 1'b0, 1'b0);
        idle(TO);
        drive(h2(ETAG), 1'b0, 1'b1);
        expect_res("R8 gap too long", 2'b10, 1'b0, 32'd0);

        // R9 restart mid packet
        arm();
        drive(DW0, 1'b1, 1'b0);
        drive(h1(3'd5, 12'd8), 1'b0, 1'b0);
        drive(DW0, 1'b1, 1'b0);
        drive(h1(3'd0, 12'd4), 1'b0, 1'b0);
        drive(h2(ETAG), 1'b0, 1'b0);
        drive(32'hCAFEF00D, 1'b0, 1'b1);
        expect_res("R9 restart", 2'b00, 1'b1, 32'hCAFEF00D);

        // R10 tag compare
        arm();
        drive(DW0, 1'b1, 1'b0);
        drive(h1(3'd0, 12'd4), 1'b0, 1'b0);
        drive(h2(ETAG ^ 8'h01), 1'b0, 1'b0);
        drive(32'h01010101, 1'b0, 1'b1);
        expect_res("R10 tag mismatch", 2'b10, 1'b0, 32'd0);
        arm();
        drive(DW0, 1'b1, 1'b0);
        drive(h1(3'd3, 12'd4), 1'b0, 1'b0);
        drive(h2(8'h00), 1'b0, 1'b1);
        expect_res("R10 tag before status", 2'b10, 1'b0, 32'd0);

        // R12 unarmed words ignored
        drive(DW0, 1'b1, 1'b0);
        drive(h1(3'd0, 12'd4), 1'b0, 1'b0);
        drive(h2(ETAG), 1'b0, 1'b0);
        drive(32'h77777777, 1'b0, 1'b1);
        idle(TO + 4);
        chk(ndone == 0, "R12 no done when unarmed", 32'(ndone), 32'd0);
        chk(code_o == 2'b10 && rdata_o == '0, "R12 outputs untouched",
            32'(code_o), 32'd2);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule